// File: doc/BRIEF.md
# Even/Odd Decimator Output Interleaver

This block gets a full-rate filtered output from two filter paths that each decimate by two. One complex input stream feeds both paths. The even path sees the input through a one-sample delay. The odd path sees it directly. Both paths run in lockstep on the same decimation phase, so each produces one result for every two input samples:

- The even path produces the filter output for the even sample index.
- The odd path produces the filter output for the odd sample index.

The block pairs these results and sends them out as a single complex stream at the undecimated rate, even result first. In effect, the filter chain performs no decimation.

Each path is modelled as a simple two-tap filter, y[k] = x[k] + x[k-1], applied to the real and imaginary parts separately. Each path keeps only the results that fall on its decimation phase.

A sync strobe, given together with a valid input, marks that sample as index 0 and clears the filter history. Each path result is held in a one-entry buffer until its partner from the other path is present, so the two halves of a pair always leave together and in order.

Top module: `eo_interleave`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, out_valid is 0.
- R2: Each output equals y[k] = x[k] + x[k-1], computed separately for the real and imaginary parts as signed W-bit inputs with a signed W+1-bit result that never overflows. x[-1] is taken as 0.
- R3: Outputs come in pairs on consecutive cycles. The first output of a pair carries the even index (out_odd = 0) and the second carries the following odd index (out_odd = 1).
- R4: When the odd-index sample k is accepted on clock edge E, y[k-1] appears with out_valid = 1 after edge E+1, and y[k] appears after edge E+2.
- R5: Each accepted odd-index sample produces exactly two outputs. An even-index sample produces none until its odd partner arrives.
- R6: An accepted sample with in_sync = 1 becomes index 0 and clears the history. An even-index sample left waiting from before the sync produces no output.
- R7: Idle cycles (in_valid = 0) between samples change neither the results nor their order.
- R8: The first sample accepted after reset is index 0 with zero history, even without a sync.
- R9: in_sync has no effect when in_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_sync | input | 1 | Marks the current valid sample as index 0 |
| in_re | input | W | Input real part, signed |
| in_im | input | W | Input imaginary part, signed |
| out_valid | output | 1 | Output sample strobe |
| out_odd | output | 1 | 1 when the output carries an odd index |
| out_re | output | W+1 | Output real part, signed |
| out_im | output | W+1 | Output imaginary part, signed |

## Verification
The main function is driven with several input patterns:

- A back-to-back ramp started straight after reset shows whether the even and odd results are interleaved in the right order, and whether the zero history at index 0 is correct.
- The same kind of stream with idle gaps tells a sample-counted phase apart from a cycle-counted one.
- A mid-stream sync placed after an unpaired even sample exposes leaked history or leftover pairs.
- A sync pulse without valid distinguishes a gated phase reset from an ungated one.
- Full-scale positive and negative values tell a widened sum from a wrapped one.
- A cycle-exact probe of one pair separates the correct two-stage latency from an off-by-one.

// File: rtl/eo_pkg.sv
package eo_pkg;
  typedef enum logic {
    MRG_PAIR = 1'b0,
    MRG_ODD  = 1'b1
  } mrg_state_t;

  localparam int PATHS = 2;
endpackage

// File: rtl/eo_delay.sv
module eo_delay #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         in_clear,
  input  logic [W-1:0] in_re,
  input  logic [W-1:0] in_im,
  output logic [W-1:0] out_re,
  output logic [W-1:0] out_im
);
  logic [W-1:0] hold_re, hold_im;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_re <= '0;
      hold_im <= '0;
    end else if (in_valid) begin
      hold_re <= in_re;
      hold_im <= in_im;
    end
  end

  // A cleared history presents zero as x[-1] for the sync sample
  assign out_re = in_clear ? '0 : hold_re;
  assign out_im = in_clear ? '0 : hold_im;
endmodule

// File: rtl/eo_dec2.sv
module eo_dec2 #(
  parameter int W = 16,
  localparam int OW = W + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_first,
  input  logic [W-1:0]  in_re,
  input  logic [W-1:0]  in_im,
  output logic          res_valid,
  output logic [OW-1:0] res_re,
  output logic [OW-1:0] res_im
);
  logic [W-1:0] prev_re, prev_im;
  logic         phase;

  function automatic logic [OW-1:0] add_ext(input logic [W-1:0] a, input logic [W-1:0] b);
    return {a[W-1], a} + {b[W-1], b};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_re   <= '0;
      prev_im   <= '0;
      phase     <= 1'b0;
      res_valid <= 1'b0;
      res_re    <= '0;
      res_im    <= '0;
    end else begin
      res_valid <= 1'b0;
      if (in_valid) begin
        prev_re <= in_re;
        prev_im <= in_im;
        if (in_first) begin
          phase <= 1'b1;
        end else if (phase) begin
          res_valid <= 1'b1;
          res_re    <= add_ext(in_re, prev_re);
          res_im    <= add_ext(in_im, prev_im);
          phase     <= 1'b0;
        end else begin
          phase <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/eo_merge.sv
module eo_merge #(
  parameter int OW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_valid,
  input  logic [OW-1:0] ev_re,
  input  logic [OW-1:0] ev_im,
  input  logic          od_valid,
  input  logic [OW-1:0] od_re,
  input  logic [OW-1:0] od_im,
  output logic          out_valid,
  output logic          out_odd,
  output logic [OW-1:0] out_re,
  output logic [OW-1:0] out_im
);
  import eo_pkg::*;

  mrg_state_t    state;
  logic          ev_full, od_full;
  logic [OW-1:0] evb_re, evb_im, odb_re, odb_im;
  logic          ev_ready, od_ready;

  assign ev_ready = ev_full | ev_valid;
  assign od_ready = od_full | od_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= MRG_PAIR;
      ev_full   <= 1'b0;
      od_full   <= 1'b0;
      evb_re    <= '0;
      evb_im    <= '0;
      odb_re    <= '0;
      odb_im    <= '0;
      out_valid <= 1'b0;
      out_odd   <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= 1'b0;
      if (state == MRG_ODD) begin
        out_valid <= 1'b1;
        out_odd   <= 1'b1;
        out_re    <= odb_re;
        out_im    <= odb_im;
        od_full   <= 1'b0;
        state     <= MRG_PAIR;
        if (ev_valid) begin
          ev_full <= 1'b1;
          evb_re  <= ev_re;
          evb_im  <= ev_im;
        end
      end else if (ev_ready && od_ready) begin
        out_valid <= 1'b1;
        out_odd   <= 1'b0;
        out_re    <= ev_full ? evb_re : ev_re;
        out_im    <= ev_full ? evb_im : ev_im;
        ev_full   <= 1'b0;
        od_full   <= 1'b1;
        if (od_valid) begin
          odb_re <= od_re;
          odb_im <= od_im;
        end
        state <= MRG_ODD;
      end else begin
        if (ev_valid) begin
          ev_full <= 1'b1;
          evb_re  <= ev_re;
          evb_im  <= ev_im;
        end
        if (od_valid) begin
          od_full <= 1'b1;
          odb_re  <= od_re;
          odb_im  <= od_im;
        end
      end
    end
  end
endmodule

// File: rtl/eo_interleave.sv
module eo_interleave #(
  parameter int W = 16,
  localparam int OW = W + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_sync,
  input  logic [W-1:0]  in_re,
  input  logic [W-1:0]  in_im,
  output logic          out_valid,
  output logic          out_odd,
  output logic [OW-1:0] out_re,
  output logic [OW-1:0] out_im
);
  import eo_pkg::*;

  logic          first;
  logic [W-1:0]  dly_re, dly_im;
  logic [W-1:0]  p_in_re  [PATHS];
  logic [W-1:0]  p_in_im  [PATHS];
  logic          p_vld    [PATHS];
  logic [OW-1:0] p_re     [PATHS];
  logic [OW-1:0] p_im     [PATHS];

  assign first = in_valid & in_sync;

  eo_delay #(.W(W)) u_delay (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_clear(first),
    .in_re(in_re), .in_im(in_im), .out_re(dly_re), .out_im(dly_im)
  );

  // path 0 yields even-time results from the delayed input, path 1 odd-time results
  for (genvar p = 0; p < PATHS; p++) begin : g_path
    if (p == 0) begin : g_even
      assign p_in_re[p] = dly_re;
      assign p_in_im[p] = dly_im;
    end else begin : g_odd
      assign p_in_re[p] = in_re;
      assign p_in_im[p] = in_im;
    end

    eo_dec2 #(.W(W)) u_dec (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(first),
      .in_re(p_in_re[p]), .in_im(p_in_im[p]),
      .res_valid(p_vld[p]), .res_re(p_re[p]), .res_im(p_im[p])
    );
  end

  eo_merge #(.OW(OW)) u_merge (
    .clk(clk), .rst(rst),
    .ev_valid(p_vld[0]), .ev_re(p_re[0]), .ev_im(p_im[0]),
    .od_valid(p_vld[1]), .od_re(p_re[1]), .od_im(p_im[1]),
    .out_valid(out_valid), .out_odd(out_odd), .out_re(out_re), .out_im(out_im)
  );
endmodule

// File: rtl/eo_interleave_chk.sv
module eo_interleave_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_sync,
  input logic out_valid,
  input logic out_odd
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R3
  even_then_odd_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_odd) |=> (out_valid && out_odd));

  // R3
  odd_follows_even_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_odd) |-> $past(out_valid && !out_odd));

  // R4
  even_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_odd) |-> $past(in_valid, 2));

  // R5
  no_double_odd_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_odd) |=> !(out_valid && out_odd));
endmodule

bind eo_interleave eo_interleave_chk u_chk (.*);

// File: tb/test_eo_interleave.sv
module test_eo_interleave;
  localparam int W = 16;
  localparam int OW = W + 1;
  localparam time PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_sync = 1'b0;
  logic [W-1:0]  in_re = '0;
  logic [W-1:0]  in_im = '0;
  logic          out_valid, out_odd;
  logic [OW-1:0] out_re, out_im;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  int m_idx = 0;
  int m_prev_re = 0, m_prev_im = 0;
  int m_ev_re = 0, m_ev_im = 0;
  int q_re[$], q_im[$];
  bit q_odd[$];

  always #(PERIOD/2) clk = ~clk;

  eo_interleave #(.W(W)) i_eo_interleave (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sync(in_sync),
    .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_odd(out_odd), .out_re(out_re), .out_im(out_im)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive one cycle from a negedge, return at the next negedge
  task automatic drive(input bit v, input bit s, input int re, input int im);
    int y_re, y_im;
    in_valid = v;
    in_sync  = s;
    in_re    = W'(re);
    in_im    = W'(im);
    if (v) begin
      if (s) begin
        m_idx = 0; m_prev_re = 0; m_prev_im = 0;
      end
      y_re = re + m_prev_re;
      y_im = im + m_prev_im;
      if (m_idx % 2 == 0) begin
        m_ev_re = y_re; m_ev_im = y_im;
      end else begin
        q_re.push_back(m_ev_re); q_im.push_back(m_ev_im); q_odd.push_back(1'b0);
        q_re.push_back(y_re);    q_im.push_back(y_im);    q_odd.push_back(1'b1);
      end
      m_idx++;
      m_prev_re = re; m_prev_im = im;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sync  = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 0, 0);
  endtask

  task automatic drain_chk(input string req);
    idle(6);
    chk(q_re.size() == 0, req, "pending outputs", q_re.size(), 0);
  endtask

  // output monitor: every output matches the next expected entry (R2, R3)
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q_re.size() == 0) begin
        chk(1'b0, "R5", "unexpected output", 1, 0);
      end else begin
        int e_re, e_im;
        bit e_odd;
        e_re = q_re.pop_front(); e_im = q_im.pop_front(); e_odd = q_odd.pop_front();
        chk($signed(out_re) == e_re, "R2", "real part", $signed(out_re), e_re);
        chk($signed(out_im) == e_im, "R2", "imag part", $signed(out_im), e_im);
        chk(out_odd == e_odd, "R3", "out_odd", out_odd, e_odd);
      end
    end
  end

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
  endtask

  task automatic t_ramp_no_sync();
    // R8: first sample after reset is index 0 with zero history
    for (int i = 0; i < 8; i++) drive(1'b1, 1'b0, 10 * i + 3, -5 * i - 1);
    drain_chk("R8");
  endtask

  task automatic t_latency();
    drive(1'b1, 1'b1, 100, -40);
    drive(1'b1, 1'b0, 7, 9);
    chk(out_valid == 1'b0, "R4", "valid after E", out_valid, 0);
    idle(1);
    chk(out_valid && !out_odd, "R4", "even after E+1", {out_valid, out_odd}, 2);
    chk($signed(out_re) == 100, "R4", "even real", $signed(out_re), 100);
    idle(1);
    chk(out_valid && out_odd, "R4", "odd after E+2", {out_valid, out_odd}, 3);
    chk($signed(out_im) == -31, "R4", "odd imag", $signed(out_im), -31);
    idle(1);
    chk(out_valid == 1'b0, "R5", "no third output", out_valid, 0);
    drain_chk("R4");
  endtask

  task automatic t_gaps();
    drive(1'b1, 1'b1, 5, 6);
    for (int i = 1; i < 7; i++) begin
      idle(i % 3 + 1);
      drive(1'b1, 1'b0, 13 * i - 20, 7 - 3 * i);
    end
    drain_chk("R7");
  endtask

  task automatic t_mid_sync();
    drive(1'b1, 1'b1, 1, 2);
    drive(1'b1, 1'b0, 3, 4);
    drive(1'b1, 1'b0, 500, 600);   // unpaired even sample, dropped by the sync
    drive(1'b1, 1'b1, 20, 30);
    drive(1'b1, 1'b0, 40, 50);
    drain_chk("R6");
  endtask

  task automatic t_sync_no_valid();
    drive(1'b1, 1'b1, 11, 12);
    drive(1'b0, 1'b1, 0, 0);        // ignored strobe
    drive(1'b1, 1'b0, 21, 22);
    drive(1'b1, 1'b0, 31, 32);
    drive(1'b0, 1'b1, 0, 0);
    drive(1'b1, 1'b0, 41, 42);
    drain_chk("R9");
  endtask

  task automatic t_extremes();
    drive(1'b1, 1'b1, 32767, -32768);
    drive(1'b1, 1'b0, 32767, -32768);
    drive(1'b1, 1'b0, -32768, 32767);
    drive(1'b1, 1'b0, -32768, -32768);
    drain_chk("R2");
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_ramp_no_sync();
    t_latency();
    t_gaps();
    t_mid_sync();
    t_sync_no_valid();
    t_extremes();
    chk(q_re.size() == 0, "R5", "leftover expected", q_re.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule